// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter that advances on a low-frequency reference tick, chosen from two single-cycle tick strobes. Software must restart it before a programmable time-out expires, but only in the late part of each period. A restart that comes while the window is still closed counts as a fault, and so does a missed time-out. In both cases the block issues a one-cycle reset pulse and records the cause.

Power-on configuration codes select the tick source, the operating mode, the period and the closed-window fraction. One period code and one window code hand the value to a software register instead. Every window code except the software one also demands that a key byte be written before the restart strobe.

Top module: `wdt_window`

## Requirements
- R1: After reset `rst_pulse_o`, `cause_to_o` and `cause_win_o` are low and the count is zero. With window code 000 this leaves `win_open_o` low.
- R2: Period code n in 0..18 gives a time-out after 32·2^n counted ticks. Codes 19..30 give 32 ticks. At time-out `rst_pulse_o` is high for exactly one cycle, `cause_to_o` is set, and counting restarts from zero.
- R3: Period code 31 selects a software period register whose reset value is 01011 (65536 ticks). A write through `sw_per_we_i` lands only while code 31 is applied.
- R4: Window codes 000..101 keep the window closed for the first 7,6,5,4,3,2 eighths of the period. Codes 110 and 111 give a window that is always open. `win_open_o` is high once the count is at least the closed part.
- R5: An accepted restart while the window is open zeroes the count and gives no pulse. An accepted restart while it is closed zeroes the count, gives a one-cycle pulse and sets `cause_win_o`.
- R6: Window codes 000..110 need the key 0x5A, written via `key_we_i` in an earlier cycle than `clr_i`. A restart with a wrong or missing key is ignored and leaves the count unchanged. Window code 111 needs no key and uses a software window register (reset 111) that is writable only while code 111 is applied.
- R7: Mode 11 runs regardless of sleep. Mode 10 runs while awake. Mode 01 runs only while `sw_en_i` is high. Mode 00 is disabled.
- R8: In mode 10 with `sleep_i` high the count is held, not cleared.
- R9: While disabled the count is forced to zero, so re-enabling starts a full period. Restarts are ignored while the counter is not running.
- R10: Source code 000 counts `tick_lf_i` and 001 counts `tick_mf_i`. Code 111 counts `tick_mf_i` when `sw_src_sel_i` is high, else `tick_lf_i`. Other codes count nothing.
- R11: `cause_clr_i[0]` clears `cause_to_o` and `cause_clr_i[1]` clears `cause_win_o`. A flag being set in the same cycle wins.
- R12: Every reset pulse comes with at least one cause flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_src_i | input | 3 | Tick source code |
| cfg_win_i | input | 3 | Window code |
| cfg_mode_i | input | 2 | Operating mode |
| cfg_per_i | input | 5 | Period code |
| sleep_i | input | 1 | Sleep indicator |
| sw_en_i | input | 1 | Software enable |
| sw_src_sel_i | input | 1 | Software tick choice for source code 111 |
| sw_per_we_i | input | 1 | Software period write strobe |
| sw_per_i | input | 5 | Software period value |
| sw_win_we_i | input | 1 | Software window write strobe |
| sw_win_i | input | 3 | Software window value |
| key_we_i | input | 1 | Key write strobe |
| key_i | input | 8 | Key byte |
| clr_i | input | 1 | Restart strobe |
| tick_lf_i | input | 1 | Low-frequency tick enable |
| tick_mf_i | input | 1 | Mid-frequency tick enable |
| cause_clr_i | input | 2 | Write-one-to-clear for cause flags |
| rst_pulse_o | output | 1 | One-cycle reset pulse |
| win_open_o | output | 1 | Restart window open |
| cause_to_o | output | 1 | Time-out cause flag |
| cause_win_o | output | 1 | Early-restart cause flag |

## Verification
The hardest case to reach from the ports is a restart that lands exactly on the count where the window opens. One count earlier must be a fault and the boundary count itself must not. The bench zeroes the counter by passing through the disabled mode, then enables it with a tick on every cycle, so the count equals the cycles elapsed. It arms the key one cycle before the restart, so that the restart is evaluated at the chosen count. It samples `win_open_o` at that count and the pulse one edge later. Time-outs are timed the same way, and the sticky time-out flag shows any early expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SW    = 2'b01,
    MODE_AWAKE = 2'b10,
    MODE_ON    = 2'b11
  } wdt_mode_e;

  localparam logic [4:0] PER_SW_CODE = 5'b11111;
  localparam logic [4:0] PER_SW_RST  = 5'b01011;
  localparam logic [2:0] WIN_SW_CODE = 3'b111;
  localparam logic [2:0] WIN_SW_RST  = 3'b111;
  localparam logic [2:0] SRC_LF      = 3'b000;
  localparam logic [2:0] SRC_MF      = 3'b001;
  localparam logic [2:0] SRC_SW      = 3'b111;
endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int PER_MAX = 18
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [4:0] cfg_per_i,
  input  logic [2:0] cfg_win_i,
  input  logic       sw_per_we_i,
  input  logic [4:0] sw_per_i,
  input  logic       sw_win_we_i,
  input  logic [2:0] sw_win_i,
  output logic [4:0] per_code_o,
  output logic [2:0] win_code_o,
  output logic       key_need_o
);
  localparam logic [4:0] PER_MAX_C = 5'(PER_MAX);

  logic [4:0] sw_per_q;
  logic [2:0] sw_win_q;
  logic [4:0] per_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_per_q <= PER_SW_RST;
      sw_win_q <= WIN_SW_RST;
    end else begin
      if (sw_per_we_i && cfg_per_i == PER_SW_CODE) sw_per_q <= sw_per_i;
      if (sw_win_we_i && cfg_win_i == WIN_SW_CODE) sw_win_q <= sw_win_i;
    end
  end

  always_comb begin
    per_sel    = (cfg_per_i == PER_SW_CODE) ? sw_per_q : cfg_per_i;
    // out-of-range codes fall back to the shortest period
    per_code_o = (per_sel > PER_MAX_C) ? 5'd0 : per_sel;
    win_code_o = (cfg_win_i == WIN_SW_CODE) ? sw_win_q : cfg_win_i;
    key_need_o = (cfg_win_i != WIN_SW_CODE);
  end
endmodule

// File: rtl/wdt_thresh.sv
module wdt_thresh #(
  parameter int CNT_W = 23,
  localparam int W = CNT_W + 1
) (
  input  logic [4:0]   per_code_i,
  input  logic [2:0]   win_code_i,
  output logic [W-1:0] period_o,
  output logic [W-1:0] thr_o
);
  logic [2:0] closed8;

  always_comb begin
    closed8  = (win_code_i > 3'd5) ? 3'd0 : 3'd7 - win_code_i;
    period_o = W'(32) << per_code_i;
    // period/8 = 4 << code, times closed eighths
    thr_o    = W'(closed8) << (per_code_i + 5'd2);
  end
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_pkg::*;
(
  input  logic [2:0] src_i,
  input  logic       sw_sel_i,
  input  logic       tick_lf_i,
  input  logic       tick_mf_i,
  output logic       tick_o
);
  always_comb begin
    case (src_i)
      SRC_LF:  tick_o = tick_lf_i;
      SRC_MF:  tick_o = tick_mf_i;
      SRC_SW:  tick_o = sw_sel_i ? tick_mf_i : tick_lf_i;
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int         CNT_W = 23,
  parameter logic [7:0] KEY   = 8'h5A,
  localparam int W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [W-1:0]     period_i,
  input  logic [W-1:0]     thr_i,
  input  logic             clr_i,
  input  logic             key_we_i,
  input  logic [7:0]       key_i,
  input  logic             key_need_i,
  input  logic [1:0]       cause_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             win_open_o,
  output logic             pulse_o,
  output logic             cause_to_o,
  output logic             cause_win_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, pulse_q, to_q, win_q;
  logic             clr_ok, expire, to_set, win_set;

  always_comb begin
    win_open_o = {1'b0, cnt_q} >= thr_i;
    clr_ok     = clr_i && run_i && (armed_q || !key_need_i);
    // >= guards against a period shortened below the live count
    expire     = {1'b0, cnt_q} >= period_i - W'(1);
    win_set    = en_i && clr_ok && !win_open_o;
    to_set     = en_i && !clr_ok && run_i && tick_i && expire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
      to_q    <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      pulse_q <= to_set || win_set;
      to_q    <= to_set  || (to_q  && !cause_clr_i[0]);
      win_q   <= win_set || (win_q && !cause_clr_i[1]);

      if (key_we_i)   armed_q <= (key_i == KEY);
      else if (clr_i) armed_q <= 1'b0;

      if (!en_i)                 cnt_q <= '0;
      else if (clr_ok)           cnt_q <= '0;
      else if (run_i && tick_i)  cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o       = cnt_q;
  assign armed_o     = armed_q;
  assign pulse_o     = pulse_q;
  assign cause_to_o  = to_q;
  assign cause_win_o = win_q;
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int         PER_MAX = 18,
  parameter logic [7:0] KEY     = 8'h5A,
  localparam int CNT_W = PER_MAX + 5,
  localparam int W     = CNT_W + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cfg_src_i,
  input  logic [2:0] cfg_win_i,
  input  logic [1:0] cfg_mode_i,
  input  logic [4:0] cfg_per_i,
  input  logic       sleep_i,
  input  logic       sw_en_i,
  input  logic       sw_src_sel_i,
  input  logic       sw_per_we_i,
  input  logic [4:0] sw_per_i,
  input  logic       sw_win_we_i,
  input  logic [2:0] sw_win_i,
  input  logic       key_we_i,
  input  logic [7:0] key_i,
  input  logic       clr_i,
  input  logic       tick_lf_i,
  input  logic       tick_mf_i,
  input  logic [1:0] cause_clr_i,
  output logic       rst_pulse_o,
  output logic       win_open_o,
  output logic       cause_to_o,
  output logic       cause_win_o
);
  logic [4:0]       per_code_w;
  logic [2:0]       win_code_w;
  logic             key_need_w, tick_w, en_w, run_w, armed_w;
  logic [W-1:0]     period_w, thr_w;
  logic [CNT_W-1:0] cnt_w;
  wdt_mode_e        mode_w;

  always_comb begin
    mode_w = wdt_mode_e'(cfg_mode_i);
    case (mode_w)
      MODE_ON, MODE_AWAKE: en_w = 1'b1;
      MODE_SW:             en_w = sw_en_i;
      default:             en_w = 1'b0;
    endcase
    run_w = en_w && !(mode_w == MODE_AWAKE && sleep_i);
  end

  wdt_cfg #(.PER_MAX(PER_MAX)) u_cfg (
    .clk_i, .rst_ni, .cfg_per_i, .cfg_win_i,
    .sw_per_we_i, .sw_per_i, .sw_win_we_i, .sw_win_i,
    .per_code_o(per_code_w), .win_code_o(win_code_w), .key_need_o(key_need_w)
  );

  wdt_thresh #(.CNT_W(CNT_W)) u_thr (
    .per_code_i(per_code_w), .win_code_i(win_code_w),
    .period_o(period_w), .thr_o(thr_w)
  );

  wdt_tick_sel u_tick (
    .src_i(cfg_src_i), .sw_sel_i(sw_src_sel_i),
    .tick_lf_i, .tick_mf_i, .tick_o(tick_w)
  );

  wdt_core #(.CNT_W(CNT_W), .KEY(KEY)) u_core (
    .clk_i, .rst_ni, .tick_i(tick_w), .en_i(en_w), .run_i(run_w),
    .period_i(period_w), .thr_i(thr_w), .clr_i, .key_we_i, .key_i,
    .key_need_i(key_need_w), .cause_clr_i,
    .cnt_o(cnt_w), .armed_o(armed_w), .win_open_o,
    .pulse_o(rst_pulse_o), .cause_to_o, .cause_win_o
  );
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk #(
  parameter int CNT_W = 23
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_w,
  input logic             run_w,
  input logic             tick_w,
  input logic             key_need_w,
  input logic             armed_w,
  input logic             clr_i,
  input logic [CNT_W-1:0] cnt_w,
  input logic             win_open_o,
  input logic             rst_pulse_o,
  input logic             cause_to_o,
  input logic             cause_win_o
);
  assert_pulse_has_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> (cause_to_o || cause_win_o));

  assert_disabled_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |=> (cnt_w == '0));

  assert_nokey_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && en_w && key_need_w && !armed_w && !(run_w && tick_w)) |=> $stable(cnt_w));

  assert_early_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && run_w && (armed_w || !key_need_w) && !win_open_o) |=> (rst_pulse_o && cause_win_o));

  assert_suspend_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && !run_w) |=> $stable(cnt_w));
endmodule

bind wdt_window wdt_window_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_w(en_w), .run_w(run_w), .tick_w(tick_w),
  .key_need_w(key_need_w), .armed_w(armed_w), .clr_i(clr_i), .cnt_w(cnt_w),
  .win_open_o(win_open_o), .rst_pulse_o(rst_pulse_o),
  .cause_to_o(cause_to_o), .cause_win_o(cause_win_o)
);

// File: tb/wdt_window_tb.sv
module wdt_window_tb;
  localparam int TCLK = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] cfg_src_i = 3'b000, cfg_win_i = 3'b000, sw_win_i = 3'b000;
  logic [1:0] cfg_mode_i = 2'b00, cause_clr_i = 2'b00;
  logic [4:0] cfg_per_i = 5'd0, sw_per_i = 5'd0;
  logic       sleep_i = 0, sw_en_i = 0, sw_src_sel_i = 0, sw_per_we_i = 0, sw_win_we_i = 0;
  logic       key_we_i = 0, clr_i = 0, tick_lf_i = 1, tick_mf_i = 0;
  logic [7:0] key_i = 8'h00;
  logic       rst_pulse_o, win_open_o, cause_to_o, cause_win_o;
  int n_chk = 0, n_bad = 0;

  always #(TCLK/2) clk_i = ~clk_i;

  wdt_window u_dut (.*);

  // {per[16:12], win[11:9], count at clear[8:1], expect violation[0]}
  localparam logic [16:0] VEC [12] = '{
    {5'd0,  3'd0, 8'd27, 1'b1}, {5'd0,  3'd0, 8'd28, 1'b0},
    {5'd0,  3'd1, 8'd23, 1'b1}, {5'd0,  3'd2, 8'd20, 1'b0},
    {5'd0,  3'd3, 8'd15, 1'b1}, {5'd0,  3'd3, 8'd16, 1'b0},
    {5'd0,  3'd5, 8'd7,  1'b1}, {5'd0,  3'd6, 8'd1,  1'b0},
    {5'd1,  3'd0, 8'd55, 1'b1}, {5'd1,  3'd0, 8'd56, 1'b0},
    {5'd20, 3'd4, 8'd11, 1'b1}, {5'd20, 3'd4, 8'd12, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // zero the counter through the disabled mode, then enable
  task automatic fresh(logic [1:0] mode);
    cfg_mode_i = 2'b00;
    @(negedge clk_i);
    cfg_mode_i = mode;
  endtask

  task automatic clr_flags();
    cause_clr_i = 2'b11;
    @(negedge clk_i);
    cause_clr_i = 2'b00;
  endtask

  // expect time-out after exactly n more counted edges
  task automatic wait_to(string tag, int n);
    repeat (n - 1) @(negedge clk_i);
    chk({tag, " no early timeout"}, {31'd0, cause_to_o}, 32'd0);
    @(negedge clk_i);
    chk({tag, " timeout pulse"}, {30'd0, rst_pulse_o, cause_to_o}, 32'd3);
    @(negedge clk_i);
    chk({tag, " pulse one cycle R2"}, {31'd0, rst_pulse_o}, 32'd0);
    clr_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    chk("R1 reset outputs", {28'd0, rst_pulse_o, win_open_o, cause_to_o, cause_win_o}, 32'd0);

    // R3 software period default 65536
    cfg_per_i = 5'd31; cfg_win_i = 3'd6;
    fresh(2'b11);
    repeat (100) @(negedge clk_i);
    chk("R3 sw period default long", {31'd0, cause_to_o}, 32'd0);
    cfg_mode_i = 2'b00;
    sw_per_we_i = 1; sw_per_i = 5'd0;
    @(negedge clk_i);
    sw_per_we_i = 0;
    fresh(2'b11);
    wait_to("R3 sw period 32", 32);
    cfg_mode_i = 2'b00; cfg_per_i = 5'd0;
    sw_per_we_i = 1; sw_per_i = 5'd2;
    @(negedge clk_i);
    sw_per_we_i = 0; cfg_per_i = 5'd31;
    fresh(2'b11);
    wait_to("R3 write ignored unless code 31", 32);
    cfg_per_i = 5'd0;

    // R4 R5 R6 R2 R11: window boundaries
    for (int i = 0; i < 12; i++) begin
      cfg_per_i = VEC[i][16:12];
      cfg_win_i = VEC[i][11:9];
      fresh(2'b11);
      repeat (int'(VEC[i][8:1]) - 1) @(negedge clk_i);
      key_we_i = 1; key_i = 8'h5A;
      @(negedge clk_i);
      key_we_i = 0;
      chk($sformatf("R4 window open vec %0d", i), {31'd0, win_open_o}, {31'd0, !VEC[i][0]});
      clr_i = 1;
      @(negedge clk_i);
      clr_i = 0;
      chk($sformatf("R5 pulse/cause vec %0d", i), {30'd0, rst_pulse_o, cause_win_o},
          {30'd0, VEC[i][0], VEC[i][0]});
      clr_flags();
      chk($sformatf("R11 flags cleared vec %0d", i), {30'd0, cause_to_o, cause_win_o}, 32'd0);
    end

    // R2 plain time-out, period code 0
    cfg_per_i = 5'd0; cfg_win_i = 3'd6;
    fresh(2'b11);
    wait_to("R2 period 32", 32);

    // R6 missing and wrong key ignored, count unchanged
    cfg_win_i = 3'd0;
    fresh(2'b11);
    repeat (4) @(negedge clk_i);
    clr_i = 1;
    @(negedge clk_i);
    clr_i = 0; key_we_i = 1; key_i = 8'h00;
    @(negedge clk_i);
    key_we_i = 0; clr_i = 1;
    @(negedge clk_i);
    clr_i = 0;
    chk("R6 unkeyed clear ignored", {30'd0, rst_pulse_o, cause_win_o}, 32'd0);
    wait_to("R6 count unchanged", 25);

    // R6 window code 111: no key, default always open
    cfg_win_i = 3'd7;
    fresh(2'b11);
    repeat (3) @(negedge clk_i);
    clr_i = 1;
    @(negedge clk_i);
    clr_i = 0;
    chk("R6 keyless clear in open window", {30'd0, rst_pulse_o, cause_win_o}, 32'd0);
    wait_to("R5 clear restarts count", 32);

    // R6 software window register, writable only under code 111
    cfg_mode_i = 2'b00;
    sw_win_we_i = 1; sw_win_i = 3'd0;
    @(negedge clk_i);
    cfg_win_i = 3'd3; sw_win_i = 3'd6;
    @(negedge clk_i);
    sw_win_we_i = 0; cfg_win_i = 3'd7;
    fresh(2'b11);
    repeat (5) @(negedge clk_i);
    clr_i = 1;
    @(negedge clk_i);
    clr_i = 0;
    chk("R6 sw window closed violation", {30'd0, rst_pulse_o, cause_win_o}, 32'd3);
    clr_flags();
    cfg_win_i = 3'd6;

    // R8 sleep holds count in mode 10
    fresh(2'b10);
    repeat (10) @(negedge clk_i);
    sleep_i = 1;
    repeat (50) @(negedge clk_i);
    chk("R8 suspended in sleep", {31'd0, cause_to_o}, 32'd0);
    sleep_i = 0;
    wait_to("R8 resumes held count", 22);

    // R7 mode 11 ignores sleep
    sleep_i = 1;
    fresh(2'b11);
    wait_to("R7 mode 11 in sleep", 32);

    // R9 clear ignored while suspended
    cfg_mode_i = 2'b10; cfg_win_i = 3'd0;
    key_we_i = 1; key_i = 8'h5A;
    @(negedge clk_i);
    key_we_i = 0; clr_i = 1;
    @(negedge clk_i);
    clr_i = 0;
    chk("R9 clear ignored when not running", {30'd0, rst_pulse_o, cause_win_o}, 32'd0);
    sleep_i = 0; cfg_win_i = 3'd6;

    // R7 mode 01 follows software enable
    sw_en_i = 0;
    fresh(2'b01);
    repeat (40) @(negedge clk_i);
    chk("R7 mode 01 stopped", {31'd0, cause_to_o}, 32'd0);
    sw_en_i = 1;
    wait_to("R7 mode 01 enabled", 32);
    sw_en_i = 0;

    // R7 mode 00 never times out
    cfg_mode_i = 2'b00;
    repeat (40) @(negedge clk_i);
    chk("R7 mode 00 disabled", {31'd0, cause_to_o}, 32'd0);

    // R9 disable restarts a full period
    fresh(2'b11);
    repeat (20) @(negedge clk_i);
    cfg_mode_i = 2'b00;
    @(negedge clk_i);
    cfg_mode_i = 2'b11;
    wait_to("R9 fresh period after disable", 32);

    // R10 tick source selection
    cfg_src_i = 3'b001; tick_lf_i = 1; tick_mf_i = 0;
    fresh(2'b11);
    repeat (40) @(negedge clk_i);
    chk("R10 code 001 ignores lf tick", {31'd0, cause_to_o}, 32'd0);
    tick_mf_i = 1;
    wait_to("R10 code 001 mf tick", 32);
    cfg_src_i = 3'b010;
    fresh(2'b11);
    repeat (40) @(negedge clk_i);
    chk("R10 reserved code no ticks", {31'd0, cause_to_o}, 32'd0);
    cfg_src_i = 3'b111; sw_src_sel_i = 1; tick_lf_i = 0;
    fresh(2'b11);
    wait_to("R10 code 111 sw select", 32);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule